// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the combinational arithmetic and logic stage of a small 32-bit load/store processor. Each cycle it takes a first operand and a second operand. The second operand arrives already formed, either as an immediate or as a shifted register value. It also takes a 4-bit operation code, the current condition flags, the carry produced by the shifter and a request to update the flags. From these it returns a 32-bit result, a write enable for the destination register and the next value of the four condition flags: negative, zero, carry and overflow.

Sixteen operations are supported. They cover plain and carry-chained addition and subtraction, including reverse forms that subtract the first operand from the second, and bitwise AND, OR, exclusive OR and bit clear. There are two moves and four test operations. The test operations set the flags without writing a destination register. The shifter, the register file and the condition evaluation that decides whether an instruction runs all sit outside this block. The surrounding pipeline registers the outputs and feeds the flags back on the next instruction.

Top module: `dp_alu`

## Requirements
- R1: Logical codes give: 0 = a AND b, 1 = a XOR b, 12 = a OR b, 13 = b, 14 = a AND NOT b, 15 = NOT b. Codes 13 and 15 do not depend on operand a.
- R2: Codes 4, 5, 2 and 6 give a+b, a+b+C, a-b and a-b-(1-C), modulo 2^32, where C is the incoming carry flag.
- R3: Code 3 gives b-a and code 7 gives b-a-(1-C), modulo 2^32.
- R4: result_we is 0 for codes 8 to 11 and 1 for every other code.
- R5: When the flags update, N equals result bit 31 and Z is 1 exactly when the 32-bit result is zero. The flag vectors are packed as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V.
- R6: On an arithmetic update, C is the adder carry out. Subtraction is formed as x + NOT y + carry-in, so C = 1 means no borrow occurred.
- R7: On an arithmetic update, V is 1 exactly when the true signed result does not fit in 32 bits.
- R8: On a logical update, C takes the shifter carry input and V keeps its incoming value.
- R9: For every code outside 8 to 11, flags_out equals flags_in when set_flags is 0.
- R10: Codes 8, 9, 10 and 11 update the flags whatever set_flags is. They base the flags on a AND b, a XOR b, a-b and a+b respectively, and place that value on result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, already shifted or immediate |
| opcode | input | 4 | Operation code 0 to 15 |
| set_flags | input | 1 | Request to update flags for non-test operations |
| flags_in | input | 4 | Current N, Z, C, V flags |
| shift_carry | input | 1 | Carry out of the external shifter |
| result | output | 32 | Operation result |
| result_we | output | 1 | Destination register write enable |
| flags_out | output | 4 | Next N, Z, C, V flags |

## Verification
Two effects can occur in the same cycle: a destination write and a flag update. An arithmetic or logical code with set_flags high produces both. A test code produces only the flag update, and a code with set_flags low produces only the write. Random stimulus draws set_flags and all sixteen codes independently, with operands biased toward zero, all-ones and the signed limits, so that carry, borrow and overflow all occur alongside a write. For every vector the bench compares result, result_we and all four flags against its own signed/unsigned reference. It reports each mismatch under the requirement that governs the field.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

  // Test-only operations: flags change, no register write.
  function automatic logic op_is_test(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

  // Operations whose result comes from the adder.
  function automatic logic op_is_arith(input logic [3:0] op);
    logic r;
    case (op)
      OP_SUB, OP_RSB, OP_ADD, OP_ADC,
      OP_SBC, OP_RSC, OP_CMP, OP_CMN: r = 1'b1;
      default:                        r = 1'b0;
    endcase
    return r;
  endfunction

  // Adder steering: swap operands, invert second adder input, carry-in source.
  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG} cin_src_e;

  typedef struct packed {
    logic     swap;
    logic     invert;
    cin_src_e cin;
  } add_ctl_t;

  function automatic add_ctl_t adder_control(input logic [3:0] op);
    add_ctl_t k;
    k = '{swap: 1'b0, invert: 1'b0, cin: CIN_ZERO};
    case (op)
      OP_SUB, OP_CMP: k = '{swap: 1'b0, invert: 1'b1, cin: CIN_ONE};
      OP_RSB:         k = '{swap: 1'b1, invert: 1'b1, cin: CIN_ONE};
      OP_ADC:         k = '{swap: 1'b0, invert: 1'b0, cin: CIN_FLAG};
      OP_SBC:         k = '{swap: 1'b0, invert: 1'b1, cin: CIN_FLAG};
      OP_RSC:         k = '{swap: 1'b1, invert: 1'b1, cin: CIN_FLAG};
      default:        k = '{swap: 1'b0, invert: 1'b0, cin: CIN_ZERO};
    endcase
    return k;
  endfunction

endpackage

// File: rtl/dp_alu_adder.sv
module dp_alu_adder
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             carry_flag,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             overflow
);

  localparam int MSB = WIDTH - 1;

  add_ctl_t         ctl;
  logic [WIDTH-1:0] x_in;
  logic [WIDTH-1:0] y_in;
  logic             c_in;
  logic [WIDTH:0]   full;

  // Signed overflow: both adder inputs agree in sign and the sum disagrees.
  function automatic logic signed_ovf(input logic xs, input logic ys, input logic ss);
    return (xs == ys) && (ss != xs);
  endfunction

  always_comb begin
    ctl  = adder_control(op);
    x_in = ctl.swap ? b : a;
    y_in = ctl.swap ? a : b;
    if (ctl.invert) y_in = ~y_in;
    case (ctl.cin)
      CIN_ONE:  c_in = 1'b1;
      CIN_FLAG: c_in = carry_flag;
      default:  c_in = 1'b0;
    endcase
    full      = {1'b0, x_in} + {1'b0, y_in} + {{WIDTH{1'b0}}, c_in};
    sum       = full[MSB:0];
    carry_out = full[WIDTH];
    overflow  = signed_ovf(x_in[MSB], y_in[MSB], full[MSB]);
  end

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res
);

  always_comb begin
    case (op)
      OP_AND, OP_TST: res = a & b;
      OP_EOR, OP_TEQ: res = a ^ b;
      OP_ORR:         res = a | b;
      OP_MOV:         res = b;
      OP_BIC:         res = a & ~b;
      OP_MVN:         res = ~b;
      default:        res = '0;
    endcase
  end

endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] value,
  input  logic             add_carry,
  input  logic             add_ovf,
  input  logic             shift_carry,
  input  logic             set_flags,
  input  alu_flags_t       flags_in,
  output alu_flags_t       flags_out,
  output logic             update
);

  localparam int MSB = WIDTH - 1;

  alu_flags_t fresh;

  always_comb begin
    update  = set_flags | op_is_test(op);
    fresh.n = value[MSB];
    fresh.z = ~|value;
    if (op_is_arith(op)) begin
      fresh.c = add_carry;
      fresh.v = add_ovf;
    end else begin
      fresh.c = shift_carry;
      fresh.v = flags_in.v;
    end
    flags_out = update ? fresh : flags_in;
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       opcode,
  input  logic             set_flags,
  input  logic [3:0]       flags_in,
  input  logic             shift_carry,
  output logic [WIDTH-1:0] result,
  output logic             result_we,
  output logic [3:0]       flags_out
);

  // Named internal events, visible to the bound checker.
  logic [WIDTH-1:0] arith_sum;
  logic             arith_carry;
  logic             arith_ovf;
  logic [WIDTH-1:0] logic_res;
  logic             sel_arith;
  logic             flag_update;
  alu_flags_t       fl_in;
  alu_flags_t       fl_out;

  assign fl_in = alu_flags_t'(flags_in);

  dp_alu_adder #(.WIDTH(WIDTH)) adder_i (
    .op         (opcode),
    .a          (op_a),
    .b          (op_b),
    .carry_flag (fl_in.c),
    .sum        (arith_sum),
    .carry_out  (arith_carry),
    .overflow   (arith_ovf)
  );

  dp_alu_logic #(.WIDTH(WIDTH)) logic_i (
    .op  (opcode),
    .a   (op_a),
    .b   (op_b),
    .res (logic_res)
  );

  always_comb begin
    sel_arith = op_is_arith(opcode);
    result    = sel_arith ? arith_sum : logic_res;
    result_we = ~op_is_test(opcode);
  end

  dp_alu_flags #(.WIDTH(WIDTH)) flags_i (
    .op          (opcode),
    .value       (result),
    .add_carry   (arith_carry),
    .add_ovf     (arith_ovf),
    .shift_carry (shift_carry),
    .set_flags   (set_flags),
    .flags_in    (fl_in),
    .flags_out   (fl_out),
    .update      (flag_update)
  );

  assign flags_out = fl_out;

endmodule

module dp_alu_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [3:0]       opcode,
  input logic             set_flags,
  input logic [3:0]       flags_in,
  input logic             shift_carry,
  input logic [WIDTH-1:0] result,
  input logic             result_we,
  input logic [3:0]       flags_out,
  input logic             sel_arith,
  input logic             flag_update
);

  localparam int MSB = WIDTH - 1;

  always_comb begin
    assert_test_no_write_R4: assert (result_we == (opcode[3:2] != 2'b10));

    if (!set_flags && result_we)
      assert_flags_hold_R9: assert (flags_out == flags_in);

    if (!result_we)
      assert_test_updates_R10: assert (flag_update);

    if (flag_update) begin
      assert_neg_zero_R5: assert (flags_out[3] == result[MSB] &&
                                  flags_out[2] == (result == '0));
    end

    if (flag_update && !sel_arith)
      assert_logic_cv_R8: assert (flags_out[1] == shift_carry &&
                                  flags_out[0] == flags_in[0]);

    if (opcode == 4'd15)
      assert_move_not_R1: assert (result == ~op_b);

    if (opcode == 4'd4)
      assert_add_sum_R2: assert (result == op_a + op_b);

    if (opcode == 4'd3)
      assert_rsb_diff_R3: assert (result == op_b - op_a);
  end

endmodule

bind dp_alu dp_alu_checker #(.WIDTH(WIDTH)) chk_i (
  .op_a        (op_a),
  .op_b        (op_b),
  .opcode      (opcode),
  .set_flags   (set_flags),
  .flags_in    (flags_in),
  .shift_carry (shift_carry),
  .result      (result),
  .result_we   (result_we),
  .flags_out   (flags_out),
  .sel_arith   (sel_arith),
  .flag_update (flag_update)
);

// File: tb/dp_alu_tb.sv
module dp_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [3:0]  opcode = '0;
  logic        set_flags = 1'b0;
  logic [3:0]  flags_in = '0;
  logic        shift_carry = 1'b0;
  logic [31:0] result;
  logic        result_we;
  logic [3:0]  flags_out;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 4 ns period

  dp_alu dut_i (
    .op_a        (op_a),
    .op_b        (op_b),
    .opcode      (opcode),
    .set_flags   (set_flags),
    .flags_in    (flags_in),
    .shift_carry (shift_carry),
    .result      (result),
    .result_we   (result_we),
    .flags_out   (flags_out)
  );

  // Reference model written from the requirements with wide signed arithmetic.
  function automatic void model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                                input logic [3:0] fi, input logic sh, input logic sf,
                                output logic [31:0] r, output logic we, output logic [3:0] fo,
                                output int kind);
    longint sx, sy, sr;
    logic [33:0] w;
    logic [31:0] x, y;
    logic c, v, cf, upd;
    cf = fi[1];
    kind = 0;  // 0 logic, 1 add, 2 subtract
    x = a; y = b;
    c = sh; v = fi[0];
    w = '0;
    r = '0;
    unique case (op)
      4'd0, 4'd8:  r = a & b;
      4'd1, 4'd9:  r = a ^ b;
      4'd12:       r = a | b;
      4'd13:       r = b;
      4'd14:       r = a & ~b;
      4'd15:       r = ~b;
      default:     kind = (op == 4'd4 || op == 4'd5 || op == 4'd11) ? 1 : 2;
    endcase
    if (op == 4'd3 || op == 4'd7) begin x = b; y = a; end
    if (kind != 0) begin
      sx = longint'($signed(x));
      sy = longint'($signed(y));
      if (kind == 1) begin
        w  = {2'b00, x} + {2'b00, y} + ((op == 4'd5) ? 34'(cf) : 34'd0);
        sr = sx + sy + ((op == 4'd5) ? longint'(cf) : 0);
        c  = w[32];
      end else begin
        w  = {2'b00, x} - {2'b00, y} - ((op == 4'd6 || op == 4'd7) ? 34'(!cf) : 34'd0);
        sr = sx - sy - ((op == 4'd6 || op == 4'd7) ? longint'(!cf) : 0);
        c  = ~w[33];
      end
      r = w[31:0];
      v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    end
    we  = !(op >= 4'd8 && op <= 4'd11);
    upd = sf || !we;
    fo  = upd ? {r[31], (r == 32'd0), c, v} : fi;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", tag, opcode, op_a, op_b, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] fi, input logic sh, input logic sf);
    logic [31:0] er;
    logic ewe;
    logic [3:0] efo;
    int kind;
    @(negedge clk);
    opcode = op; op_a = a; op_b = b; flags_in = fi; shift_carry = sh; set_flags = sf;
    #1;
    model(op, a, b, fi, sh, sf, er, ewe, efo, kind);
    if (op >= 4'd8 && op <= 4'd11)   check("R10 result", result, er);
    else if (op == 4'd3 || op == 4'd7) check("R3 result", result, er);
    else if (kind != 0)                check("R2 result", result, er);
    else                               check("R1 result", result, er);
    check("R4 result_we", 32'(result_we), 32'(ewe));
    if (!sf && ewe) check("R9 flags held", 32'(flags_out), 32'(efo));
    else begin
      check("R5 N/Z", 32'(flags_out[3:2]), 32'(efo[3:2]));
      if (kind != 0) begin
        check("R6 carry", 32'(flags_out[1]), 32'(efo[1]));
        check("R7 overflow", 32'(flags_out[0]), 32'(efo[0]));
      end else begin
        check("R8 logic C/V", 32'(flags_out[1:0]), 32'(efo[1:0]));
      end
    end
  endtask

  function automatic logic [31:0] pick();
    logic [31:0] corner [5];
    corner = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1};
    if ($urandom_range(3) == 0) return corner[$urandom_range(4)];
    return $urandom;
  endfunction

  initial begin
    #(4 * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset-state vector: all inputs zero.
    apply(4'd0, 32'h0, 32'h0, 4'b0000, 1'b0, 1'b0);
    // R2/R7: signed overflow on add.
    apply(4'd4, 32'h7FFF_FFFF, 32'h1, 4'b0000, 1'b0, 1'b1);
    // R6: borrow on 0-1 gives C=0.
    apply(4'd2, 32'h0, 32'h1, 4'b0000, 1'b0, 1'b1);
    // R6: unsigned wrap on add gives C=1, Z=1.
    apply(4'd4, 32'hFFFF_FFFF, 32'h1, 4'b0000, 1'b0, 1'b1);
    // R10: compare equal with set_flags low still updates, no write.
    apply(4'd10, 32'h1234_5678, 32'h1234_5678, 4'b0000, 1'b0, 1'b0);
    // R10: TST/TEQ/CMN.
    apply(4'd8, 32'hF0F0_0000, 32'h0F0F_0000, 4'b1011, 1'b1, 1'b0);
    apply(4'd9, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 4'b0000, 1'b0, 1'b0);
    apply(4'd11, 32'h8000_0000, 32'h8000_0000, 4'b0000, 1'b0, 1'b0);
    // R3: reverse subtract with and without carry.
    apply(4'd3, 32'h5, 32'h3, 4'b0000, 1'b0, 1'b1);
    apply(4'd7, 32'h3, 32'h5, 4'b0000, 1'b0, 1'b1);
    apply(4'd7, 32'h3, 32'h5, 4'b0010, 1'b0, 1'b1);
    // R2: carry-chained subtract and add.
    apply(4'd6, 32'h0, 32'h0, 4'b0000, 1'b0, 1'b1);
    apply(4'd5, 32'hFFFF_FFFF, 32'h0, 4'b0010, 1'b0, 1'b1);
    // R9: no update when set_flags is low.
    apply(4'd4, 32'hFFFF_FFFF, 32'h1, 4'b1010, 1'b0, 1'b0);
    // R1: MVN and MOV independent of op_a; BIC.
    apply(4'd15, 32'h0, 32'h00FF_00FF, 4'b0000, 1'b0, 1'b1);
    apply(4'd15, 32'hDEAD_BEEF, 32'h00FF_00FF, 4'b0000, 1'b0, 1'b1);
    apply(4'd13, 32'hDEAD_BEEF, 32'h0, 4'b0001, 1'b1, 1'b1);
    apply(4'd14, 32'hFFFF_FFFF, 32'h0000_FFFF, 4'b0000, 1'b0, 1'b1);
    // R8: logical op keeps V, takes shifter carry.
    apply(4'd12, 32'h8000_0000, 32'h1, 4'b0001, 1'b1, 1'b1);
    for (int i = 0; i < 4000; i++) begin
      apply(4'($urandom_range(15)), pick(), pick(), 4'($urandom_range(15)),
            1'($urandom_range(1)), 1'($urandom_range(1)));
    end
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule